// File: doc/BRIEF.md
# Prioritised Interrupt Level Arbiter

This block sits between a set of interrupt sources and a processor core. Each source has its own configuration entry, which holds a vector number, a request level from 0 to 7 and a sub-priority from 0 to 7. Level 0 switches the source off. Levels 1 to 7 rank requests, and 7 is the most urgent. Among the enabled sources that are requesting, the arbiter picks a winner in two tiers. The level decides first. The sub-priority then breaks ties within that level, and the lower source index breaks any tie that remains.

The winner is compared with the core's 3-bit interrupt mask, which follows the status-register convention. A mask value m holds off every level at or below m. Level 7 is the exception: it is never held off, even when the mask is 7. When the winner passes the mask, its level appears on a registered pending-level output. Otherwise that output reads 0. When the core raises its acknowledge input, the arbiter takes the winner of that same cycle. One cycle later it returns that winner's vector together with a one-cycle valid strobe. If nothing is pending, it returns the spurious vector, 24.

Software sets up each source through a single-entry write port that carries an index, a vector, a level and a sub-priority.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `pend_level` is 0, `vec_valid` is 0 and every source has level 0, so it is disabled.
- R2: A source whose level is 0 never wins arbitration, whatever its sub-priority.
- R3: Among the enabled sources that are requesting, the one with the highest level (1 lowest, 7 highest) wins.
- R4: Within the winning level, the higher sub-priority wins. When sub-priorities are equal, the lower source index wins.
- R5: A mask value m (0..7) blocks winners whose level is at or below m. When the winner is blocked, `pend_level` reads 0.
- R6: A level-7 winner is presented on `pend_level` as 7 for every mask value, including 7.
- R7: `pend_level` is registered. It reflects `req`, `mask` and the configuration as they stood before the previous rising clock edge.
- R8: When `ack` is high at a rising edge, `vec_valid` is high after that edge for one cycle. `vec_out` then holds the vector of the source that was winning and unmasked at that edge. `vec_valid` is low in every cycle that does not follow an `ack` edge.
- R9: If no unmasked winner exists at the `ack` edge, `vec_out` returns the spurious vector 24 (decimal).
- R10: When `cfg_we` is high at a rising edge, entry `cfg_idx` takes `cfg_vector`, `cfg_level` and `cfg_sub`. Arbitration uses the new entry from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NSRC | Request line per source, active high |
| mask | input | 3 | Core interrupt mask, status-register convention |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Source entry to write |
| cfg_vector | input | VW | Vector number for the entry |
| cfg_level | input | 3 | Request level, 0 = disabled |
| cfg_sub | input | 3 | Sub-priority within the level |
| ack | input | 1 | Acknowledge from the core |
| pend_level | output | 3 | Level presented to the core, 0 = none |
| vec_valid | output | 1 | Vector return strobe |
| vec_out | output | VW | Returned vector number |

## Verification
A corrupted configuration entry or a wrong winner shows at the next edge in two places. `pend_level` carries the wrong level, or the vector returned one cycle after an acknowledge names the wrong source. The bench sets sub-priorities and indices that tie on purpose, so an inverted comparison or a swapped tie-break shows up as a wrong vector rather than staying hidden behind a correct level. A mask comparison that is off by one shows within a cycle at the blocking boundaries m = level and m = level - 1, and at mask 7 with a level-7 request.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned VW = 8,
  parameter logic [VW-1:0] SPURIOUS = 8'd24,
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [2:0]      mask,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [VW-1:0]   cfg_vector,
  input  logic [2:0]      cfg_level,
  input  logic [2:0]      cfg_sub,
  input  logic            ack,
  output logic [2:0]      pend_level,
  output logic            vec_valid,
  output logic [VW-1:0]   vec_out
);

  logic [VW-1:0] vec_q [NSRC];
  logic [2:0]    lvl_q [NSRC];
  logic [2:0]    sub_q [NSRC];

  logic [5:0]    win_key;
  logic [VW-1:0] win_vec;
  logic [2:0]    win_lvl;
  logic          pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        vec_q[i] <= '0;
        lvl_q[i] <= '0;
        sub_q[i] <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < NSRC)) begin
      vec_q[cfg_idx] <= cfg_vector;
      lvl_q[cfg_idx] <= cfg_level;
      sub_q[cfg_idx] <= cfg_sub;
    end
  end

  always_comb begin
    win_key = '0;
    win_vec = SPURIOUS;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && lvl_q[i] != 3'd0 && {lvl_q[i], sub_q[i]} > win_key) begin
        win_key = {lvl_q[i], sub_q[i]};
        win_vec = vec_q[i];
      end
    end
  end

  assign win_lvl = win_key[5:3];
  assign pass    = (win_lvl == 3'd7) || (win_lvl > mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_level <= '0;
      vec_valid  <= 1'b0;
      vec_out    <= '0;
    end else begin
      pend_level <= pass ? win_lvl : 3'd0;
      vec_valid  <= ack;
      if (ack) vec_out <= pass ? win_vec : SPURIOUS;
    end
  end

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int unsigned NSRC = 8,
  parameter int unsigned VW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req,
  input logic [2:0]      mask,
  input logic            ack,
  input logic [2:0]      pend_level,
  input logic            vec_valid,
  input logic [VW-1:0]   vec_out
);

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_level == 3'd0 || pend_level == 3'd7 || pend_level > $past(mask));

  // R8
  strobe_only_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  // R8
  strobe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  // R9
  spurious_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req == '0) |=> (vec_out == VW'(24)));

  // R2
  idle_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req == '0 |=> pend_level == 3'd0);

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .ack(ack),
  .pend_level(pend_level), .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [2:0] mask = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_vector = '0;
  logic [2:0] cfg_level = '0;
  logic [2:0] cfg_sub = '0;
  logic       ack = 1'b0;
  logic [2:0] pend_level;
  logic       vec_valid;
  logic [7:0] vec_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vector(cfg_vector),
    .cfg_level(cfg_level), .cfg_sub(cfg_sub), .ack(ack),
    .pend_level(pend_level), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // entry: {req[7:0], mask[2:0], exp_level[2:0], exp_vec[7:0]}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {8'h00, 3'd0, 3'd0, 8'd24},   // R9 nothing requesting
    {8'h01, 3'd0, 3'd3, 8'h40},   // R3 single source
    {8'h03, 3'd0, 3'd3, 8'h41},   // R4 higher sub wins
    {8'h22, 3'd0, 3'd3, 8'h41},   // R4 equal sub, lower index
    {8'h84, 3'd0, 3'd5, 8'h42},   // R4 equal sub at level 5
    {8'h10, 3'd0, 3'd0, 8'd24},   // R2 disabled source alone
    {8'h13, 3'd0, 3'd3, 8'h41},   // R2 disabled sub 7 loses
    {8'h05, 3'd0, 3'd5, 8'h42},   // R3 level 5 over level 3
    {8'h05, 3'd5, 3'd0, 8'd24},   // R5 mask equal to level blocks
    {8'h05, 3'd4, 3'd5, 8'h42},   // R5 mask one below passes
    {8'h08, 3'd7, 3'd7, 8'h43},   // R6 level 7 through mask 7
    {8'h0D, 3'd7, 3'd7, 8'h43},   // R6 others blocked, 7 passes
    {8'h40, 3'd1, 3'd0, 8'd24},   // R5 mask 1 blocks level 1
    {8'h40, 3'd0, 3'd1, 8'h46},   // R3 lowest level passes mask 0
    {8'hFF, 3'd6, 3'd7, 8'h43}    // R6 all requesting, mask 6
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input int v, input int l, input int s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_vector = 8'(v);
    cfg_level = 3'(l); cfg_sub = 3'(s);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, all sources disabled
    check("R1 pend_level", pend_level, 0);
    check("R1 vec_valid", vec_valid, 0);
    req = 8'hFF;
    @(negedge clk);
    check("R1 sources disabled", pend_level, 0);
    req = 8'h00;

    cfg_write(0, 8'h40, 3, 2);
    cfg_write(1, 8'h41, 3, 5);
    cfg_write(2, 8'h42, 5, 1);
    cfg_write(3, 8'h43, 7, 0);
    cfg_write(4, 8'h44, 0, 7);
    cfg_write(5, 8'h45, 3, 5);
    cfg_write(6, 8'h46, 1, 0);
    cfg_write(7, 8'h47, 5, 1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      req = VEC[k][21:14];
      mask = VEC[k][13:11];
      @(negedge clk);
      check($sformatf("R3/R5 vec %0d pend_level", k), pend_level, int'(VEC[k][10:8]));
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      check($sformatf("R8 vec %0d vec_valid", k), vec_valid, 1);
      check($sformatf("R8/R9 vec %0d vec_out", k), vec_out, int'(VEC[k][7:0]));
      @(negedge clk);
      check($sformatf("R8 vec %0d strobe one cycle", k), vec_valid, 0);
    end

    // R7 registered latency
    @(negedge clk);
    req = 8'h01; mask = 3'd0;
    @(negedge clk);
    check("R7 settled", pend_level, 3);
    req = 8'h04;
    #1;
    check("R7 no change before edge", pend_level, 3);
    @(negedge clk);
    check("R7 change after one edge", pend_level, 5);

    // R10 config timing: write source 6 to level 6 while it requests
    @(negedge clk);
    req = 8'h40; mask = 3'd0;
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_vector = 8'h66;
    cfg_level = 3'd6; cfg_sub = 3'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 old entry used at write edge", pend_level, 1);
    @(negedge clk);
    check("R10 new level next edge", pend_level, 6);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R10 new vector returned", vec_out, 8'h66);

    // R9 masked winner gives spurious vector
    mask = 3'd6;
    @(negedge clk);
    check("R5 level 6 blocked by mask 6", pend_level, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R9 masked winner spurious", vec_out, 24);

    // R2 disabling a source by writing level 0
    cfg_write(3, 8'h43, 0, 7);
    req = 8'h08; mask = 3'd0;
    @(negedge clk);
    @(negedge clk);
    check("R2 level 0 after rewrite", pend_level, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule